// File: doc/BRIEF.md
# Channel-Interleaved to Row-Major Flattening Controller

This block sits between the output of a convolution stage and a fully connected engine. Convolution results arrive one element per beat in channel-group order. A fixed-size group of elements belongs to one channel, then a group of the same size follows for the next channel, and after the last channel the next group of the first channel arrives. The fully connected engine needs each channel's elements as one unbroken run, with one channel after another. The block writes every arriving group into a storage bank reserved for its channel. When the whole frame is stored, it reads the banks out one after another.

A frame holds `CH` channels of `elem_count` elements each. `elem_count` is the height times the width of the convolution output, for example 49 for a 7×7 map. It must not exceed the bank depth and is taken to be a multiple of the group size. Flattening runs only while `flat_en` is high. When `flat_en` is low, for example for a fully connected layer fed by another fully connected layer whose output is already flat, data and handshake pass straight through. Both edges use a valid/ready handshake. A beat transfers in a cycle where valid and ready are both high at the rising clock edge.

Top module: `flat_reorder`

## Requirements
- R1: After reset with `flat_en` high, `out_valid` is low and `in_ready` is high.
- R2: In flatten mode, beat k of a frame (counting from 0) belongs to channel (k / GROUP) mod CH and is element GROUP·(k / (GROUP·CH)) + (k mod GROUP) of that channel. A frame is CH·`elem_count` beats long. The default values are GROUP = 4 and CH = 4.
- R3: The stored frame leaves as all `elem_count` elements of channel 0 in index order, then channel 1, and so on up to channel CH-1.
- R4: In flatten mode, `in_ready` and `out_valid` are never high in the same cycle. Input is refused for the whole time the banks are draining.
- R5: `out_valid` rises in the cycle right after the edge that accepts the final input beat of a frame.
- R6: `in_ready` is high in the cycle right after the edge that accepts the final output element of a frame.
- R7: In flatten mode, while `out_valid` is high and `out_ready` is low, the next cycle still shows `out_valid` high with the same `out_data`.
- R8: `elem_count` is captured when the first beat of a frame is accepted. Changing it later in the same frame does not alter the frame length or the output.
- R9: A frame with `elem_count` equal to the bank depth `DEPTH` is stored and emitted in full and in order.
- R10: With `flat_en` low, `out_valid` equals `in_valid`, `out_data` equals `in_data`, and `in_ready` equals `out_ready` in every cycle.
- R11: Lowering `flat_en` for at least one cycle discards a partly stored frame or a frame still waiting to drain. When `flat_en` is raised again, the next accepted beat is treated as the first beat of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| flat_en | input | 1 | 1: reorder frames; 0: pass data through |
| elem_count | input | $clog2(DEPTH+1) | Elements per channel (H×W), captured at frame start |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts the input beat |
| in_data | input | DATA_W | Input element |
| out_valid | output | 1 | Output element present |
| out_ready | input | 1 | Consumer accepts the output element |
| out_data | output | DATA_W | Output element |

## Verification
Two functions can meet in one cycle: the drain of a stored frame can be stalled by a consumer, and in the same cycle the mode switch can remove flattening. The bench provokes this by holding `out_ready` low after a complete frame has been accepted and then dropping `flat_en` while the frame is still pending. It judges the result in three ways. The output must follow the pass-through path at once. On re-enable `in_ready` must be high with `out_valid` low. The next full frame must come out in correct row-major order, with no element left over from the discarded frame. A second meeting point is a stalled output coinciding with the drain of the last element of a channel. This is exercised with a pseudo-random `out_ready` pattern, and every stalled cycle is checked for a stable element.

// File: rtl/flat_pkg.sv
package flat_pkg;

   // Which side of a frame the block is working on in flatten mode
   typedef enum logic {
      PH_FILL  = 1'b0,
      PH_DRAIN = 1'b1
   } phase_t;

   // Number of bits needed to hold values 0..n
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/flat_scatter.sv
// Write-side sequencer: walks position-in-group, channel and group base,
// and steers each accepted beat to the bank of its channel.
module flat_scatter #(
   parameter int unsigned CH     = 4,
   parameter int unsigned GROUP  = 4,
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned CNT_W  = flat_pkg::cnt_bits(DEPTH),
   parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_fire,
   input  logic [CNT_W-1:0]  count_in,
   output logic [CH-1:0]     wr_onehot,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              frame_done,
   output logic [CNT_W-1:0]  frame_count
);
   localparam int unsigned CH_W  = $clog2(CH);
   localparam int unsigned POS_W = $clog2(GROUP);

   logic [POS_W-1:0] pos_q;
   logic [CH_W-1:0]  ch_q;
   logic [CNT_W-1:0] base_q;
   logic [CNT_W-1:0] cnt_q;
   logic             started_q;

   logic last_pos, last_ch, last_grp;
   logic [CNT_W-1:0] cur_count;
   logic [CNT_W-1:0] elem_idx;

   assign cur_count  = started_q ? cnt_q : count_in;
   assign last_pos   = (pos_q == POS_W'(GROUP - 1));
   assign last_ch    = (ch_q == CH_W'(CH - 1));
   assign last_grp   = ((base_q + CNT_W'(GROUP)) >= cur_count);
   assign frame_done = wr_fire && last_pos && last_ch && last_grp;
   assign frame_count = cur_count;

   assign elem_idx = base_q + CNT_W'(pos_q);
   assign wr_addr  = elem_idx[ADDR_W-1:0];

   for (genvar c = 0; c < CH; c++) begin : g_sel
      assign wr_onehot[c] = wr_fire && (ch_q == CH_W'(c));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q     <= '0;
         ch_q      <= '0;
         base_q    <= '0;
         cnt_q     <= '0;
         started_q <= 1'b0;
      end else if (clr || frame_done) begin
         pos_q     <= '0;
         ch_q      <= '0;
         base_q    <= '0;
         started_q <= 1'b0;
      end else if (wr_fire) begin
         started_q <= 1'b1;
         if (!started_q) begin
            cnt_q <= count_in;
         end
         if (last_pos) begin
            pos_q <= '0;
            if (last_ch) begin
               ch_q   <= '0;
               base_q <= base_q + CNT_W'(GROUP);
            end else begin
               ch_q <= ch_q + 1'b1;
            end
         end else begin
            pos_q <= pos_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/flat_bank.sv
// One channel's storage: a single write port and an asynchronous read port.
module flat_bank #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/flat_drain.sv
// Read-side sequencer: after a frame is stored, walks every element of
// channel 0, then channel 1, up to the last channel.
module flat_drain #(
   parameter int unsigned CH     = 4,
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned CNT_W  = flat_pkg::cnt_bits(DEPTH),
   parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   start,
   input  logic [CNT_W-1:0]       count_in,
   input  logic                   rd_fire,
   output flat_pkg::phase_t       phase,
   output logic [$clog2(CH)-1:0]  rd_ch,
   output logic [ADDR_W-1:0]      rd_addr
);
   localparam int unsigned CH_W = $clog2(CH);

   flat_pkg::phase_t phase_q;
   logic [CH_W-1:0]  ch_q;
   logic [CNT_W-1:0] idx_q;
   logic [CNT_W-1:0] cnt_q;
   logic             end_of_ch;

   assign end_of_ch = ((idx_q + 1'b1) == cnt_q);
   assign phase     = phase_q;
   assign rd_ch     = ch_q;
   assign rd_addr   = idx_q[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= flat_pkg::PH_FILL;
         ch_q    <= '0;
         idx_q   <= '0;
         cnt_q   <= '0;
      end else if (clr) begin
         phase_q <= flat_pkg::PH_FILL;
         ch_q    <= '0;
         idx_q   <= '0;
      end else if (start) begin
         phase_q <= flat_pkg::PH_DRAIN;
         ch_q    <= '0;
         idx_q   <= '0;
         cnt_q   <= count_in;
      end else if (rd_fire && phase_q == flat_pkg::PH_DRAIN) begin
         if (end_of_ch) begin
            idx_q <= '0;
            if (ch_q == CH_W'(CH - 1)) begin
               phase_q <= flat_pkg::PH_FILL;
               ch_q    <= '0;
            end else begin
               ch_q <= ch_q + 1'b1;
            end
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/flat_reorder.sv
// Channel-group interleaved to row-major flattening controller (top).
module flat_reorder #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CH     = 4,
   parameter int unsigned GROUP  = 4,
   parameter int unsigned DEPTH  = 64
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               flat_en,
   input  logic [flat_pkg::cnt_bits(DEPTH)-1:0] elem_count,
   input  logic                               in_valid,
   output logic                               in_ready,
   input  logic [DATA_W-1:0]                  in_data,
   output logic                               out_valid,
   input  logic                               out_ready,
   output logic [DATA_W-1:0]                  out_data
);
   localparam int unsigned CNT_W  = flat_pkg::cnt_bits(DEPTH);
   localparam int unsigned ADDR_W = $clog2(DEPTH);
   localparam int unsigned CH_W   = $clog2(CH);

   // elaboration-time parameter checks
   if (CH < 2 || GROUP < 2) begin : g_bad_shape
      $error("flat_reorder: CH and GROUP must each be at least 2");
   end
   if ((DEPTH % GROUP) != 0) begin : g_bad_depth
      $error("flat_reorder: DEPTH must be a multiple of GROUP");
   end
   if ((1 << CH_W) != CH) begin : g_bad_ch
      $error("flat_reorder: CH must be a power of two");
   end

   flat_pkg::phase_t  phase;
   logic              clr;
   logic              draining;
   logic              wr_fire;
   logic              rd_fire;
   logic              frame_done;
   logic [CH-1:0]     wr_onehot;
   logic [ADDR_W-1:0] wr_addr;
   logic [ADDR_W-1:0] rd_addr;
   logic [CH_W-1:0]   rd_ch;
   logic [CNT_W-1:0]  frame_count;
   logic [DATA_W-1:0] bank_rd [CH];

   assign clr      = !flat_en;
   assign draining = (phase == flat_pkg::PH_DRAIN);

   assign in_ready  = flat_en ? !draining : out_ready;
   assign out_valid = flat_en ? draining  : in_valid;
   assign out_data  = flat_en ? bank_rd[rd_ch] : in_data;

   assign wr_fire = flat_en && !draining && in_valid;
   assign rd_fire = flat_en && draining && out_ready;

   flat_scatter #(
      .CH(CH), .GROUP(GROUP), .DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
   ) u_scatter (
      .clk(clk),
      .rst_n(rst_n),
      .clr(clr),
      .wr_fire(wr_fire),
      .count_in(elem_count),
      .wr_onehot(wr_onehot),
      .wr_addr(wr_addr),
      .frame_done(frame_done),
      .frame_count(frame_count)
   );

   for (genvar c = 0; c < CH; c++) begin : g_bank
      flat_bank #(
         .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
      ) u_bank (
         .clk(clk),
         .we(wr_onehot[c]),
         .waddr(wr_addr),
         .wdata(in_data),
         .raddr(rd_addr),
         .rdata(bank_rd[c])
      );
   end

   flat_drain #(
      .CH(CH), .DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
   ) u_drain (
      .clk(clk),
      .rst_n(rst_n),
      .clr(clr),
      .start(frame_done),
      .count_in(frame_count),
      .rd_fire(rd_fire),
      .phase(phase),
      .rd_ch(rd_ch),
      .rd_addr(rd_addr)
   );
endmodule

// File: rtl/flat_reorder_chk.sv
module flat_reorder_chk #(
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flat_en,
   input logic              in_valid,
   input logic              in_ready,
   input logic [DATA_W-1:0] in_data,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data
);
   // R4
   fill_drain_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flat_en |-> !(in_ready && out_valid));

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flat_en && out_valid && !out_ready) |=> (!flat_en || (out_valid && $stable(out_data))));

   // R10
   bypass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flat_en && out_valid) |-> (out_data == in_data));

   // R10
   bypass_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flat_en |-> (in_ready == out_ready));

   // R5
   drain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flat_en && $past(flat_en) && $rose(out_valid)) |-> $past(in_valid && in_ready));

   // R6
   refill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flat_en && $past(flat_en) && $rose(in_ready)) |-> $past(out_valid && out_ready));
endmodule

bind flat_reorder flat_reorder_chk #(.DATA_W(DATA_W)) u_flat_reorder_chk (
   .clk(clk),
   .rst_n(rst_n),
   .flat_en(flat_en),
   .in_valid(in_valid),
   .in_ready(in_ready),
   .in_data(in_data),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_data(out_data)
);

// File: tb/flat_reorder_bench.sv
module flat_reorder_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W = 16;
   localparam int CH     = 4;
   localparam int GROUP  = 4;
   localparam int DEPTH  = 64;
   localparam int CNT_W  = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flat_en = 1'b1;
   logic [CNT_W-1:0] elem_count = '0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [DATA_W-1:0] in_data = '0;
   logic out_valid;
   logic out_ready = 1'b1;
   logic [DATA_W-1:0] out_data;

   int n_checks = 0;
   int n_fail = 0;
   int rdy_mode = 0;        // 0 always ready, 1 pseudo-random, 2 held low
   logic [15:0] lfsr = 16'hACE1;
   logic [DATA_W-1:0] exp_q[$];
   bit excl_bad = 0;
   bit prev_stall = 0;
   logic [DATA_W-1:0] prev_data = '0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flat_reorder #(.DATA_W(DATA_W), .CH(CH), .GROUP(GROUP), .DEPTH(DEPTH)) u_flat_reorder (
      .clk(clk), .rst_n(rst_n), .flat_en(flat_en), .elem_count(elem_count),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // consumer ready pattern, changed just after each rising edge
   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rdy_mode)
         0: out_ready = 1'b1;
         1: out_ready = lfsr[0] | lfsr[5];
         default: out_ready = 1'b0;
      endcase
   end

   // monitor: scoreboard compare, exclusivity flag, stall stability
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3", "unexpected output", int'(out_data), 0);
            end else begin
               logic [DATA_W-1:0] e;
               e = exp_q.pop_front();
               chk(out_data === e, "R3", "output element", int'(out_data), int'(e));
            end
         end
         if (flat_en && in_ready && out_valid) excl_bad = 1;
         if (flat_en && prev_stall) begin
            chk(out_valid && out_data === prev_data, "R7", "stalled element held",
                int'(out_data), int'(prev_data));
         end
         prev_stall = flat_en && out_valid && !out_ready;
         prev_data  = out_data;
      end
   end

   task automatic put(input logic [DATA_W-1:0] d);
      bit acc;
      in_valid = 1'b1;
      in_data  = d;
      do begin
         @(negedge clk);
         acc = in_ready;
         @(posedge clk);
         #1;
      end while (!acc);
      in_valid = 1'b0;
   endtask

   function automatic logic [DATA_W-1:0] elem(input int seed, input int ch, input int idx);
      return {4'(seed), 2'(ch), 10'(idx)};
   endfunction

   // R2: interleaved drive; expected queue filled row-major (R3)
   task automatic send_frame(input int cnt, input int seed, input bit bump_count, input bit expect_out);
      elem_count = CNT_W'(cnt);
      if (expect_out) begin
         for (int c = 0; c < CH; c++)
            for (int i = 0; i < cnt; i++) exp_q.push_back(elem(seed, c, i));
      end
      for (int g = 0; g < cnt; g += GROUP)
         for (int c = 0; c < CH; c++)
            for (int p = 0; p < GROUP; p++) begin
               put(elem(seed, c, g + p));
               if (bump_count && g == 0 && c == 0 && p == 0) elem_count = CNT_W'(cnt + 2 * GROUP); // R8
            end
      chk(out_valid === 1'b1, "R5", "out_valid after last input", int'(out_valid), 1);
   endtask

   task automatic wait_drain(input string req);
      excl_bad = 0;
      while (exp_q.size() != 0) begin
         @(posedge clk);
         #1;
      end
      chk(in_ready === 1'b1, "R6", "in_ready after last output", int'(in_ready), 1);
      chk(!excl_bad, "R4", "in_ready with out_valid", int'(excl_bad), 0);
      chk(out_valid === 1'b0, req, "idle after frame", int'(out_valid), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid === 1'b0, "R1", "out_valid at reset", int'(out_valid), 0);
      chk(in_ready === 1'b1, "R1", "in_ready at reset", int'(in_ready), 1);
      @(posedge clk);
      #1;

      // R2 R3: single group per channel
      send_frame(GROUP, 1, 0, 1);
      wait_drain("R3");

      // R7: several groups under random back-pressure
      rdy_mode = 1;
      send_frame(3 * GROUP, 2, 0, 1);
      wait_drain("R7");
      rdy_mode = 0;

      // R8: count changed after the first beat
      send_frame(2 * GROUP, 3, 1, 1);
      wait_drain("R8");

      // R9: full bank depth
      rdy_mode = 1;
      send_frame(DEPTH, 4, 0, 1);
      wait_drain("R9");

      // R10: pass-through under back-pressure
      flat_en = 1'b0;
      for (int k = 0; k < 12; k++) begin
         exp_q.push_back(DATA_W'(16'h5A00 + k));
         put(DATA_W'(16'h5A00 + k));
      end
      @(negedge clk);
      chk(in_ready === out_ready, "R10", "ready mirrors consumer", int'(in_ready), int'(out_ready));
      while (exp_q.size() != 0) begin
         @(posedge clk);
         #1;
      end
      chk(out_valid === 1'b0, "R10", "out_valid follows idle input", int'(out_valid), 0);
      rdy_mode = 0;
      flat_en = 1'b1;
      @(posedge clk);
      #1;

      // R11: partial frame discarded
      for (int k = 0; k < 6; k++) put(DATA_W'(16'hEE00 + k));
      flat_en = 1'b0;
      @(posedge clk);
      #1;
      flat_en = 1'b1;
      @(negedge clk);
      chk(out_valid === 1'b0 && in_ready === 1'b1, "R11", "state after partial discard",
          int'({out_valid, in_ready}), 1);
      @(posedge clk);
      #1;
      send_frame(2 * GROUP, 5, 0, 1);
      wait_drain("R11");

      // R11: stored frame discarded while its drain is stalled
      rdy_mode = 2;
      send_frame(GROUP, 6, 0, 1);
      @(posedge clk);
      #1;
      flat_en = 1'b0;
      exp_q.delete();
      @(negedge clk);
      chk(out_valid === in_valid, "R10", "bypass takes over at once", int'(out_valid), int'(in_valid));
      @(posedge clk);
      #1;
      flat_en = 1'b1;
      rdy_mode = 0;
      @(negedge clk);
      chk(out_valid === 1'b0 && in_ready === 1'b1, "R11", "state after pending discard",
          int'({out_valid, in_ready}), 1);
      @(posedge clk);
      #1;
      send_frame(GROUP, 7, 0, 1);
      wait_drain("R11");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end
endmodule